// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block sits between a simple single-request port and an asynchronous parallel NOR-style flash bus. A request carries an operation code, a word address and a data word. The sequencer turns the request into the unlock write cycles the device expects, then runs the last command cycle. After that it polls the device until the operation finishes and pulses `done`, with `error` set on failure. Every bus cycle is built from clock-counted intervals. The ns figures are parameters and are converted to cycles against the clock period. Outputs are the address, write data, a data-drive enable and the three active-low strobes.

Completion is detected in the bus cycles themselves. The sequencer reads the request address again and again, and the operation is finished once status bit 6 returns the same value on two successive reads. The sequencer does not wait a fixed time. An identification request reads two words in the identification mode, leaves the mode and returns both words. The bus has no tri-state pad logic. `f_drive` tells the pad ring when to drive.

Controller states are named as follows. IDLE accepts a request and moves to CMD, or to DONE for an undefined code. CMD issues one command write per step and moves to POLL_A on its last step, or to ID0 for identification. POLL_A moves to POLL_B after its first read. POLL_B moves to DONE when bit 6 matches, stays in POLL_B when it differs, and moves to EXIT when it differs after the poll limit. ID0 moves to ID1. ID1 moves to EXIT. EXIT writes the leave-mode code and moves to DONE. DONE returns to IDLE. The bus engine has its own states: E_IDLE, then E_ADDR, E_ACT, E_HOLD and E_GAP for a write, or E_ACT and E_GAP for a read.

Top module: `flash_cmd_seq`

## Requirements
- R1: During and right after reset, `req_ready`=1, `done`=0, `error`=0, `f_drive`=0 and `f_ce_n`, `f_we_n`, `f_oe_n` are all 1.
- R2: Op code 0 (program) writes data/address pairs 00AA@5555, 0055@2AAA, 00A0@5555, then req_data@req_addr. Bits 15..8 are zero in every command cycle.
- R3: Op 1 (sector erase) writes AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, then 30@req_addr. Op 2 (chip erase) writes the same five cycles and ends with 10@5555. Op 3 (boot lock) writes the same five cycles and ends with 40@5555.
- R4: During each write cycle, `f_oe_n` is high and `f_ce_n` is low while `f_we_n` is low. `f_we_n` stays low for at least ceil(T_WP_NS/period) cycles and stays high for at least ceil(T_WPH_NS/period) cycles between pulses. Address and data do not change while `f_we_n` is low.
- R5: After the last command write of ops 0 to 3, the block reads req_addr repeatedly. It finishes without error on the first read whose bit 6 equals the bit 6 of the read just before it. `f_oe_n` stays high for at least ceil(T_OEHP_NS/period) cycles between reads.
- R6: Op 4 (identify) writes AA@5555, 55@2AAA, 90@5555, reads address 0 and then address 1, and writes F0@5555. `rd_data` returns {second word, first word}. No polling takes place.
- R7: If bit 6 still differs on a poll read that completes once POLL_MAX_CYC cycles of polling have passed, the block writes F0@5555 and pulses `done` with `error`=1. It then accepts new requests again.
- R8: `req_ready` drops in the cycle after acceptance and rises in the cycle after the one-cycle `done` pulse. While `req_ready` is low, `req_valid` has no effect and no extra bus cycles occur.
- R9: Op codes 5 to 7 complete with `done` and `error`=1 and produce no bus cycle.
- R10: `f_drive` is high only during write cycles and is never high while `f_oe_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_op | input | 3 | Operation code (0 program, 1 sector erase, 2 chip erase, 3 boot lock, 4 identify) |
| req_addr | input | AW | Target or sector word address |
| req_data | input | DW | Program data |
| req_ready | output | 1 | Idle and able to accept a request |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Valid with done: poll timeout or undefined op |
| rd_data | output | 2*DW | Identification words {addr 1, addr 0} |
| f_addr | output | AW | Flash address |
| f_dout | output | DW | Flash write data |
| f_drive | output | 1 | Data-pad drive enable |
| f_din | input | DW | Flash read data |
| f_ce_n | output | 1 | Chip enable, active low |
| f_we_n | output | 1 | Write enable, active low |
| f_oe_n | output | 1 | Output enable, active low |

## Verification
The bench varies the number of toggling status reads a flash model returns. It covers both parities of that count and the case where the first two reads already agree. A sequencer that compares against the wrong read, or that stops on the first read, returns a poll count different from the one the bench computes. A model that never stops toggling exercises the timeout: a broken design either hangs or skips the leave-mode write. Undefined op codes, and a `req_valid` held high during an operation, expose a sequencer that issues stray cycles. Strobe width checks catch any interval that is short by a cycle.

// File: rtl/flash_seq_pkg.sv
`timescale 1ns/1ps
package flash_seq_pkg;

    typedef enum logic [2:0] {
        OP_PROG   = 3'd0,
        OP_SERASE = 3'd1,
        OP_CERASE = 3'd2,
        OP_LOCK   = 3'd3,
        OP_IDRD   = 3'd4
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE, S_CMD, S_POLL_A, S_POLL_B, S_ID0, S_ID1, S_EXIT, S_DONE
    } seq_state_e;

    typedef enum logic [2:0] {
        E_IDLE, E_ADDR, E_ACT, E_HOLD, E_GAP
    } bus_state_e;

    localparam logic [15:0] KEY_ADDR_A = 16'h5555;
    localparam logic [15:0] KEY_ADDR_B = 16'h2AAA;

    function automatic int cyc_of(input int ns, input int clk_ps);
        int c;
        c = (ns * 1000 + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max_i(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fl_cmd_rom.sv
`timescale 1ns/1ps
module fl_cmd_rom
    import flash_seq_pkg::*;
#(
    parameter int AW = 19,
    parameter int DW = 16
) (
    input  op_e           op,
    input  logic [2:0]    step,
    input  logic [AW-1:0] tgt_addr,
    input  logic [DW-1:0] tgt_data,
    output logic [AW-1:0] c_addr,
    output logic [DW-1:0] c_data,
    output logic          c_last
);
    logic [7:0] code;
    logic       at_tgt;

    always_comb begin
        code   = 8'hAA;
        at_tgt = 1'b0;
        c_addr = AW'(KEY_ADDR_A);
        unique case (step)
            3'd0: code = 8'hAA;
            3'd1: begin code = 8'h55; c_addr = AW'(KEY_ADDR_B); end
            3'd2: code = (op == OP_PROG) ? 8'hA0 : ((op == OP_IDRD) ? 8'h90 : 8'h80);
            3'd3: if (op == OP_PROG) at_tgt = 1'b1;
            3'd4: begin code = 8'h55; c_addr = AW'(KEY_ADDR_B); end
            3'd5: begin
                if (op == OP_SERASE) begin code = 8'h30; c_addr = tgt_addr; end
                else if (op == OP_CERASE) code = 8'h10;
                else code = 8'h40;
            end
            default: code = 8'hAA;
        endcase
        if (at_tgt) begin
            c_addr = tgt_addr;
            c_data = tgt_data;
        end else begin
            c_data = DW'(code);
        end
        c_last = (op == OP_IDRD && step == 3'd2) || (op == OP_PROG && step == 3'd3) ||
                 (step == 3'd5);
    end
endmodule

// File: rtl/fl_bus_engine.sv
`timescale 1ns/1ps
module fl_bus_engine
    import flash_seq_pkg::*;
#(
    parameter int AW     = 19,
    parameter int DW     = 16,
    parameter int CW     = 8,
    parameter int C_SU   = 3,
    parameter int C_WP   = 25,
    parameter int C_HD   = 3,
    parameter int C_WPH  = 13,
    parameter int C_RD   = 50,
    parameter int C_OEHP = 38
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue,
    input  logic          is_read,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_data,
    output logic          cyc_done,
    output logic [DW-1:0] rdata,
    output logic [AW-1:0] f_addr,
    output logic [DW-1:0] f_dout,
    output logic          f_drive,
    input  logic [DW-1:0] f_din,
    output logic          f_ce_n,
    output logic          f_we_n,
    output logic          f_oe_n
);
    bus_state_e    st, st_nx;
    logic [CW-1:0] cnt, cnt_nx;
    logic          rd_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= E_IDLE;
            cnt    <= '0;
            rd_q   <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
            rdata  <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
            if (st == E_IDLE && issue) begin
                rd_q   <= is_read;
                addr_q <= in_addr;
                data_q <= in_data;
            end
            if (st == E_ACT && rd_q && cnt == '0) rdata <= f_din;
        end
    end

    always_comb begin
        st_nx  = st;
        cnt_nx = (cnt == '0) ? '0 : cnt - CW'(1);
        unique case (st)
            E_IDLE: if (issue) begin
                if (is_read) begin st_nx = E_ACT;  cnt_nx = CW'(C_RD - 1); end
                else         begin st_nx = E_ADDR; cnt_nx = CW'(C_SU - 1); end
            end
            E_ADDR: if (cnt == '0) begin st_nx = E_ACT; cnt_nx = CW'(C_WP - 1); end
            E_ACT: if (cnt == '0) begin
                if (rd_q) begin st_nx = E_GAP;  cnt_nx = CW'(C_OEHP - 1); end
                else      begin st_nx = E_HOLD; cnt_nx = CW'(C_HD - 1); end
            end
            E_HOLD: if (cnt == '0) begin st_nx = E_GAP; cnt_nx = CW'(C_WPH - 1); end
            E_GAP:  if (cnt == '0) st_nx = E_IDLE;
            default: st_nx = E_IDLE;
        endcase
    end

    always_comb begin
        f_ce_n   = !(st == E_ADDR || st == E_ACT || st == E_HOLD);
        f_we_n   = !(st == E_ACT && !rd_q);
        f_oe_n   = !(st == E_ACT && rd_q);
        f_drive  = !rd_q && (st == E_ADDR || st == E_ACT || st == E_HOLD);
        cyc_done = (st == E_GAP) && (cnt == '0);
        f_addr   = addr_q;
        f_dout   = data_q;
    end
endmodule

// File: rtl/flash_cmd_seq.sv
`timescale 1ns/1ps
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter int AW           = 19,
    parameter int DW           = 16,
    parameter int CLK_PS       = 4000,
    parameter int T_SU_NS      = 10,
    parameter int T_WP_NS      = 100,
    parameter int T_HD_NS      = 10,
    parameter int T_WPH_NS     = 50,
    parameter int T_RD_NS      = 200,
    parameter int T_OEHP_NS    = 150,
    parameter int POLL_MAX_CYC = 1000000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [2:0]      req_op,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   req_data,
    output logic            req_ready,
    output logic            done,
    output logic            error,
    output logic [2*DW-1:0] rd_data,
    output logic [AW-1:0]   f_addr,
    output logic [DW-1:0]   f_dout,
    output logic            f_drive,
    input  logic [DW-1:0]   f_din,
    output logic            f_ce_n,
    output logic            f_we_n,
    output logic            f_oe_n
);
    localparam int C_SU   = cyc_of(T_SU_NS, CLK_PS);
    localparam int C_WP   = cyc_of(T_WP_NS, CLK_PS);
    localparam int C_HD   = cyc_of(T_HD_NS, CLK_PS);
    localparam int C_WPH  = cyc_of(T_WPH_NS, CLK_PS);
    localparam int C_RD   = cyc_of(T_RD_NS, CLK_PS);
    localparam int C_OEHP = cyc_of(T_OEHP_NS, CLK_PS);
    localparam int CMAX   = max_i(max_i(max_i(C_SU, C_WP), max_i(C_HD, C_WPH)), max_i(C_RD, C_OEHP));
    localparam int CW     = $clog2(CMAX + 1);
    localparam int PW     = $clog2(POLL_MAX_CYC + 1);

    seq_state_e    st, st_nx;
    op_e           op_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic [2:0]    step;
    logic          err_q, tog_q;
    logic [PW-1:0] pcnt;
    logic [DW-1:0] id0_q, id1_q;
    logic          op_bad, poll_same, poll_over;

    logic          issue, b_read, eng_done;
    logic [AW-1:0] b_addr, c_addr;
    logic [DW-1:0] b_data, c_data, eng_rdata;
    logic          c_last;

    fl_cmd_rom #(.AW(AW), .DW(DW)) i_rom (
        .op(op_q), .step(step), .tgt_addr(addr_q), .tgt_data(data_q),
        .c_addr(c_addr), .c_data(c_data), .c_last(c_last)
    );

    fl_bus_engine #(
        .AW(AW), .DW(DW), .CW(CW), .C_SU(C_SU), .C_WP(C_WP), .C_HD(C_HD),
        .C_WPH(C_WPH), .C_RD(C_RD), .C_OEHP(C_OEHP)
    ) i_eng (
        .clk(clk), .rst_n(rst_n), .issue(issue), .is_read(b_read),
        .in_addr(b_addr), .in_data(b_data), .cyc_done(eng_done), .rdata(eng_rdata),
        .f_addr(f_addr), .f_dout(f_dout), .f_drive(f_drive), .f_din(f_din),
        .f_ce_n(f_ce_n), .f_we_n(f_we_n), .f_oe_n(f_oe_n)
    );

    assign op_bad    = (req_op > 3'd4);
    assign poll_same = (eng_rdata[6] == tog_q);
    assign poll_over = (pcnt >= PW'(POLL_MAX_CYC));

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= S_IDLE;
            op_q   <= OP_PROG;
            addr_q <= '0;
            data_q <= '0;
            step   <= '0;
            err_q  <= 1'b0;
            tog_q  <= 1'b0;
            pcnt   <= '0;
            id0_q  <= '0;
            id1_q  <= '0;
        end else begin
            st <= st_nx;
            unique case (st)
                S_IDLE: if (req_valid) begin
                    op_q   <= op_e'(req_op);
                    addr_q <= req_addr;
                    data_q <= req_data;
                    step   <= '0;
                    err_q  <= op_bad;
                    pcnt   <= '0;
                end
                S_CMD: if (eng_done) step <= step + 3'd1;
                S_POLL_A, S_POLL_B: begin
                    if (!poll_over) pcnt <= pcnt + PW'(1);
                    if (eng_done) begin
                        tog_q <= eng_rdata[6];
                        if (st == S_POLL_B && !poll_same && poll_over) err_q <= 1'b1;
                    end
                end
                S_ID0: if (eng_done) id0_q <= eng_rdata;
                S_ID1: if (eng_done) id1_q <= eng_rdata;
                default: ;
            endcase
        end
    end

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:   if (req_valid) st_nx = op_bad ? S_DONE : S_CMD;
            S_CMD:    if (eng_done && c_last) st_nx = (op_q == OP_IDRD) ? S_ID0 : S_POLL_A;
            S_POLL_A: if (eng_done) st_nx = S_POLL_B;
            S_POLL_B: if (eng_done) begin
                if (poll_same)      st_nx = S_DONE;
                else if (poll_over) st_nx = S_EXIT;
            end
            S_ID0:    if (eng_done) st_nx = S_ID1;
            S_ID1:    if (eng_done) st_nx = S_EXIT;
            S_EXIT:   if (eng_done) st_nx = S_DONE;
            S_DONE:   st_nx = S_IDLE;
            default:  st_nx = S_IDLE;
        endcase
    end

    // outputs and bus request mux
    always_comb begin
        req_ready = (st == S_IDLE);
        done      = (st == S_DONE);
        error     = (st == S_DONE) && err_q;
        rd_data   = {id1_q, id0_q};
        issue     = 1'b1;
        b_read    = 1'b1;
        b_addr    = addr_q;
        b_data    = '0;
        unique case (st)
            S_CMD:              begin b_read = 1'b0; b_addr = c_addr; b_data = c_data; end
            S_POLL_A, S_POLL_B: b_addr = addr_q;
            S_ID0:              b_addr = '0;
            S_ID1:              b_addr = AW'(1);
            S_EXIT:             begin b_read = 1'b0; b_addr = AW'(KEY_ADDR_A); b_data = DW'(8'hF0); end
            default:            issue = 1'b0;
        endcase
    end
endmodule

// File: rtl/flash_seq_chk.sv
`timescale 1ns/1ps
module flash_seq_chk
    import flash_seq_pkg::*;
#(
    parameter int AW       = 19,
    parameter int DW       = 16,
    parameter int CLK_PS   = 4000,
    parameter int T_WP_NS  = 100,
    parameter int T_WPH_NS = 50
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          done,
    input logic          error,
    input logic [AW-1:0] f_addr,
    input logic [DW-1:0] f_dout,
    input logic          f_drive,
    input logic          f_ce_n,
    input logic          f_we_n,
    input logic          f_oe_n
);
    localparam int C_WP  = cyc_of(T_WP_NS, CLK_PS);
    localparam int C_WPH = cyc_of(T_WPH_NS, CLK_PS);
    localparam int SAT   = 1000000;

    int lo_cnt, hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_cnt <= 0;
            hi_cnt <= SAT;
        end else if (!f_we_n) begin
            lo_cnt <= (lo_cnt < SAT) ? lo_cnt + 1 : lo_cnt;
            hi_cnt <= 0;
        end else begin
            lo_cnt <= 0;
            hi_cnt <= (hi_cnt < SAT) ? hi_cnt + 1 : hi_cnt;
        end
    end

    AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(f_we_n) |-> lo_cnt >= C_WP); // R4
    AST_WE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(f_we_n) |-> hi_cnt >= C_WPH); // R4
    AST_STROBE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !f_we_n |-> (!f_ce_n && f_oe_n)); // R4
    AST_STROBE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!f_we_n && !$past(f_we_n)) |-> ($stable(f_addr) && $stable(f_dout))); // R4
    AST_READ_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !f_oe_n |-> (!f_ce_n && f_we_n)); // R5
    AST_DRIVE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        f_drive |-> f_oe_n); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_BUSY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_ready); // R8
    AST_ERR_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> done); // R7
endmodule

bind flash_cmd_seq flash_seq_chk #(
    .AW(AW), .DW(DW), .CLK_PS(CLK_PS), .T_WP_NS(T_WP_NS), .T_WPH_NS(T_WPH_NS)
) i_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done), .error(error),
    .f_addr(f_addr), .f_dout(f_dout), .f_drive(f_drive), .f_ce_n(f_ce_n),
    .f_we_n(f_we_n), .f_oe_n(f_oe_n)
);

// File: tb/test_flash_cmd_seq.sv
`timescale 1ns/1ps
module test_flash_cmd_seq;
    localparam int AW = 19;
    localparam int DW = 16;
    localparam int WP_MIN   = 25;   // 100 ns at 4 ns
    localparam int WPH_MIN  = 13;   // 50 ns rounded up
    localparam int OEHP_MIN = 38;   // 150 ns rounded up

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [2:0]      req_op = '0;
    logic [AW-1:0]   req_addr = '0;
    logic [DW-1:0]   req_data = '0;
    logic            req_ready, done, error;
    logic [2*DW-1:0] rd_data;
    logic [AW-1:0]   f_addr;
    logic [DW-1:0]   f_dout, f_din;
    logic            f_drive, f_ce_n, f_we_n, f_oe_n;

    always #2 clk = ~clk;

    flash_cmd_seq #(.AW(AW), .DW(DW), .POLL_MAX_CYC(3000)) i_flash_cmd_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .req_ready(req_ready),
        .done(done), .error(error), .rd_data(rd_data), .f_addr(f_addr),
        .f_dout(f_dout), .f_drive(f_drive), .f_din(f_din), .f_ce_n(f_ce_n),
        .f_we_n(f_we_n), .f_oe_n(f_oe_n)
    );

    int total = 0, bad = 0, cyc = 0;
    bit id_mode = 0, tog = 0, m_busy = 0, first_we = 1;
    int busy_left = 0, we_lo = 0, we_hi = 0, oe_hi = 1000;
    logic prev_we = 1'b1, prev_oe = 1'b1;
    logic [AW+DW-1:0] wlog[$], exq[$];
    logic [AW-1:0]    raddr[$];
    logic             got_err;
    logic [2*DW-1:0]  got_rd;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // flash model read data
    always_comb begin
        if (f_ce_n || f_oe_n)  f_din = '1;
        else if (id_mode)      f_din = (f_addr == 0) ? 16'h001F : ((f_addr == 1) ? 16'h00A3 : 16'h0000);
        else if (busy_left > 0) f_din = {9'h000, tog, 6'b010101};
        else                   f_din = 16'h0055;
    end

    // monitor, sampled on the falling edge
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++;
            $display("FAIL watchdog act=%0d exp=<150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
        if (!rst_n) begin
            chk(req_ready && !done && f_ce_n && f_we_n && f_oe_n && !f_drive, "R1 reset",
                {27'd0, req_ready, done, f_ce_n, f_we_n, f_oe_n}, 32'h17);
        end else begin
            chk(req_ready == !m_busy, "R8 ready", req_ready, !m_busy);
            if (done) m_busy = 0;
            else if (!m_busy && req_valid) m_busy = 1;
            if (f_drive && !f_oe_n) chk(0, "R10 drive", f_drive, 0);
            if (!f_we_n && (f_ce_n || !f_oe_n)) chk(0, "R4 frame", {f_ce_n, f_oe_n}, 2'b01);
            if (prev_we && !f_we_n) begin
                if (!first_we) chk(we_hi >= WPH_MIN, "R4 gap", we_hi, WPH_MIN);
                first_we = 0;
                we_lo = 0;
            end
            if (!prev_we && f_we_n) begin
                chk(we_lo >= WP_MIN, "R4 width", we_lo, WP_MIN);
                wlog.push_back({f_addr, f_dout});
                if (f_addr == AW'(16'h5555) && f_dout == 16'h0090) id_mode = 1;
                if (f_dout == 16'h00F0) id_mode = 0;
                we_hi = 0;
            end
            if (!f_we_n) we_lo++; else we_hi++;
            if (prev_oe && !f_oe_n) begin
                chk(oe_hi >= OEHP_MIN, "R5 oe gap", oe_hi, OEHP_MIN);
            end
            if (!prev_oe && f_oe_n) begin
                raddr.push_back(f_addr);
                if (busy_left > 0) begin busy_left--; tog = ~tog; end
                oe_hi = 0;
            end
            if (f_oe_n) oe_hi++;
            prev_we = f_we_n;
            prev_oe = f_oe_n;
        end
    end

    function automatic int exp_polls(input int k);
        int prev = (k > 0) ? 0 : 1;
        for (int i = 1; i < k + 4; i++) begin
            int cur = (i < k) ? (i % 2) : 1;
            if (cur == prev) return i + 1;
            prev = cur;
        end
        return -1;
    endfunction

    task automatic push(input logic [15:0] a, input logic [15:0] d);
        exq.push_back({AW'(a), d});
    endtask

    task automatic build(input int op, input logic [AW-1:0] a, input logic [15:0] d);
        exq.delete();
        push(16'h5555, 16'h00AA);
        push(16'h2AAA, 16'h0055);
        if (op == 0) begin
            push(16'h5555, 16'h00A0);
            exq.push_back({a, d});
        end else if (op == 4) begin
            push(16'h5555, 16'h0090);
            push(16'h5555, 16'h00F0);
        end else begin
            push(16'h5555, 16'h0080);
            push(16'h5555, 16'h00AA);
            push(16'h2AAA, 16'h0055);
            if (op == 1) exq.push_back({a, 16'h0030});
            else if (op == 2) push(16'h5555, 16'h0010);
            else push(16'h5555, 16'h0040);
        end
    endtask

    task automatic cmp_writes(input string req);
        chk(wlog.size() == exq.size(), req, wlog.size(), exq.size());
        for (int i = 0; i < wlog.size() && i < exq.size(); i++)
            chk(wlog[i] == exq[i], req, wlog[i], exq[i]);
    endtask

    task automatic run_req(input logic [2:0] op, input logic [AW-1:0] a, input logic [15:0] d,
                           input int busy, input bit hold);
        int n = 0;
        wlog.delete();
        raddr.delete();
        busy_left = busy;
        tog = 0;
        oe_hi = 1000;
        @(posedge clk); #1;
        req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
        @(posedge clk); #1;
        if (hold) begin
            req_op = 3'd2;
            repeat (60) @(posedge clk);
            #1;
        end
        req_valid = 1'b0;
        do begin @(negedge clk); n++; end while (!done && n < 60000);
        got_err = error;
        got_rd  = rd_data;
        repeat (2) @(posedge clk);
    endtask

    task automatic poll_case(input logic [2:0] op, input logic [AW-1:0] a, input logic [15:0] d,
                             input int busy, input string rw);
        run_req(op, a, d, busy, 0);
        build(op, a, d);
        cmp_writes(rw);
        chk(got_err == 0, "R5 no error", got_err, 0);
        chk(raddr.size() == exp_polls(busy), "R5 poll count", raddr.size(), exp_polls(busy));
        foreach (raddr[i]) chk(raddr[i] == a, "R5 poll addr", raddr[i], a);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !done && !error && f_ce_n && f_we_n && f_oe_n && !f_drive, "R1 after reset",
            {26'd0, req_ready, done, error, f_ce_n, f_we_n, f_oe_n}, 32'h27);

        poll_case(3'd0, 19'h12345, 16'hBEEF, 4, "R2 program");
        poll_case(3'd0, 19'h00321, 16'h0F0E, 3, "R2 program odd");
        poll_case(3'd0, 19'h00007, 16'h1234, 0, "R2 program idle");
        poll_case(3'd1, 19'h7E000, 16'h0000, 7, "R3 sector erase");
        poll_case(3'd2, 19'h00000, 16'h0000, 2, "R3 chip erase");
        poll_case(3'd3, 19'h00000, 16'h0000, 1, "R3 lock");

        run_req(3'd4, 19'h0, 16'h0, 0, 0);
        build(4, 19'h0, 16'h0);
        cmp_writes("R6 id writes");
        chk(raddr.size() == 2, "R6 id reads", raddr.size(), 2);
        if (raddr.size() == 2) begin
            chk(raddr[0] == 0, "R6 first addr", raddr[0], 0);
            chk(raddr[1] == 1, "R6 second addr", raddr[1], 1);
        end
        chk(got_rd == 32'h00A3001F, "R6 id words", got_rd, 32'h00A3001F);
        chk(got_err == 0, "R6 no error", got_err, 0);

        run_req(3'd1, 19'h7D000, 16'h0, 100000, 0);
        build(1, 19'h7D000, 16'h0);
        push(16'h5555, 16'h00F0);
        cmp_writes("R7 timeout writes");
        chk(got_err == 1, "R7 timeout error", got_err, 1);
        chk(req_ready == 1, "R7 back to idle", req_ready, 1);
        poll_case(3'd0, 19'h00100, 16'h5A5A, 0, "R7 usable after timeout");

        for (int op = 5; op < 8; op++) begin
            run_req(3'(op), 19'h00040, 16'h0, 0, 0);
            chk(got_err == 1, "R9 bad op error", got_err, 1);
            chk(wlog.size() == 0 && raddr.size() == 0, "R9 no bus cycle",
                wlog.size() + raddr.size(), 0);
        end

        run_req(3'd0, 19'h00200, 16'h00C3, 2, 1);
        build(0, 19'h00200, 16'h00C3);
        cmp_writes("R8 valid ignored while busy");
        chk(raddr.size() == exp_polls(2), "R8 poll count", raddr.size(), exp_polls(2));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule